// File: doc/BRIEF.md
# Two-Wire Bus Line Deglitcher and Condition Detector

This block sits between the raw clock and data lines of a two-wire serial bus and the slave state machine that decodes bytes from them. It runs on a system clock much faster than the bus clock. Both lines are first brought into the system clock domain by a two-flop synchroniser. A pulse-width filter then removes any excursion that is shorter than a set number of system clock cycles. With the default setting this is about 100 ns at 125 MHz.

From the filtered levels the block produces single-cycle pulses for the following events:
- bus clock rising edge, where the slave samples data;
- bus clock falling edge, where the slave may change the data it drives;
- START, a high-to-low data transition while the filtered clock is high;
- STOP, a low-to-high data transition while the filtered clock is high.

Any data change while the clock is high is reported only as a condition and never as data. The filtered levels are also provided as outputs. After reset both lines read as an idle, high bus.

Top module: `bus_line_conditioner`

## Requirements
- R1: While reset is low and in the first cycle after it, `scl_level` and `sda_level` read 1 and every pulse output reads 0.
- R2: A raw SDA excursion lasting fewer than `FILT_CYCLES` system clock edges leaves `sda_level` unchanged and produces no START or STOP pulse.
- R3: A raw SCL excursion lasting fewer than `FILT_CYCLES` system clock edges leaves `scl_level` unchanged and produces no edge pulse.
- R4: A raw level held for at least `FILT_CYCLES` edges is passed on. The filtered output takes the new value on the (`FILT_CYCLES`+2)-th rising system clock edge after the raw change: two edges for the synchroniser and `FILT_CYCLES` edges for the filter.
- R5: Each 0-to-1 change of `scl_level` produces exactly one `scl_rise` pulse, one cycle wide, in the cycle where `scl_level` first reads 1.
- R6: Each 1-to-0 change of `scl_level` produces exactly one `scl_fall` pulse, one cycle wide, in the cycle where `scl_level` first reads 0.
- R7: A 1-to-0 change of `sda_level` while `scl_level` is 1 before and after the change produces exactly one `start_det` pulse.
- R8: A 0-to-1 change of `sda_level` while `scl_level` is 1 before and after the change produces exactly one `stop_det` pulse.
- R9: SDA changes made while `scl_level` is 0 produce neither START nor STOP.
- R10: Every pulse output is at most one cycle wide. `start_det` and `stop_det` are never high together, and neither are `scl_rise` and `scl_fall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_raw | input | 1 | Unsynchronised bus clock line |
| sda_raw | input | 1 | Unsynchronised bus data line |
| scl_level | output | 1 | Filtered bus clock level |
| sda_level | output | 1 | Filtered bus data level |
| scl_rise | output | 1 | One-cycle pulse on a filtered clock rise |
| scl_fall | output | 1 | One-cycle pulse on a filtered clock fall |
| start_det | output | 1 | One-cycle START pulse |
| stop_det | output | 1 | One-cycle STOP pulse |

## Verification
The assertions assume that the raw inputs are already sampled cleanly by the first synchroniser stage. They also assume that a START or STOP is meant only when the filtered clock has been high for at least two cycles.

The stimulus changes the raw lines only at falling system clock edges, so every excursion spans a whole number of rising edges. Clock and data are never moved in the same cycle. Bus clock phases are held well beyond the filter width before the data line moves, so each condition is unambiguous.

// File: rtl/bus_line_pkg.sv
// Package: shared definitions for the two-wire line conditioner.
// Assumes: nothing beyond IEEE 1800-2017.
package bus_line_pkg;

    // Idle level of both lines on an unloaded pulled-up bus.
    localparam logic LINE_IDLE = 1'b1;

    // Filtered snapshot of both lines.
    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

endpackage

// File: rtl/bus_line_sync.sv
// Module: two-flop synchroniser for one asynchronous line.
// Assumes: the line idles high; reset is synchronous and active low.
module bus_line_sync
    import bus_line_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchroniser flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{LINE_IDLE}};
        else        chain_q <= {chain_q[STAGES-2:0], line_in};
    end

    assign line_out = chain_q[STAGES-1];

endmodule

// File: rtl/bus_glitch_filter.sv
// Module: pulse-width filter. The output follows the input only after the
// input has differed from the output for FILT_CYCLES consecutive edges.
// Assumes: the input is already synchronous to clk.
module bus_glitch_filter
    import bus_line_pkg::*;
#(
    parameter int FILT_CYCLES = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic filt_out
);

    localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          filt_q;

    // Count the cycles of disagreement and flip the output once the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            filt_q <= LINE_IDLE;
        end else if (sync_in == filt_q) begin
            run_q  <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_q <= sync_in;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign filt_out = filt_q;

    AST_FLIP_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(sync_in) == filt_q)); // R4
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LAST); // R4
    AST_AGREE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in == filt_q) |=> (run_q == '0)); // R2

endmodule

// File: rtl/bus_cond_detect.sv
// Module: derives clock edge pulses and START/STOP pulses from filtered lines.
// Assumes: both inputs are filtered and synchronous; the lines idle high at reset.
module bus_cond_detect
    import bus_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_pair_t cur,
    output logic       scl_rise,
    output logic       scl_fall,
    output logic       start_det,
    output logic       stop_det
);

    line_pair_t prev_q;

    // Remember the previous filtered levels of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '{scl: LINE_IDLE, sda: LINE_IDLE};
        else        prev_q <= cur;
    end

    logic scl_held_high;

    // Decode edges and conditions from the previous and current levels.
    always_comb begin
        scl_held_high = prev_q.scl & cur.scl;
        scl_rise      = ~prev_q.scl & cur.scl;
        scl_fall      = prev_q.scl & ~cur.scl;
        start_det     = scl_held_high & prev_q.sda & ~cur.sda;
        stop_det      = scl_held_high & ~prev_q.sda & cur.sda;
    end

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise); // R5
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_fall); // R6
    AST_START_LEAVES_SDA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!prev_q.sda && prev_q.scl)); // R7
    AST_STOP_LEAVES_SDA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (prev_q.sda && prev_q.scl)); // R8
    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)); // R10
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall)); // R10
    AST_NO_COND_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise || scl_fall) |-> !(start_det || stop_det)); // R9

endmodule

// File: rtl/bus_line_conditioner.sv
// Module: top of the line conditioner. Each line passes through a
// synchroniser and then a glitch filter, and the filtered pair drives the
// condition detector.
// Assumes: clk is much faster than the bus clock; reset is synchronous, active low.
module bus_line_conditioner
    import bus_line_pkg::*;
#(
    parameter int FILT_CYCLES = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_level,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_v, sync_v, filt_v;
    line_pair_t        filt_pair;

    assign raw_v = {scl_raw, sda_raw};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        bus_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_v[i]),
            .line_out (sync_v[i])
        );
        bus_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_v[i]),
            .filt_out (filt_v[i])
        );
    end

    assign filt_pair = '{scl: filt_v[1], sda: filt_v[0]};
    assign scl_level = filt_pair.scl;
    assign sda_level = filt_pair.sda;

    bus_cond_detect det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (filt_pair),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (scl_level && sda_level && !start_det && !stop_det)); // R1

endmodule

// File: tb/bus_line_conditioner_tb_top.sv
module bus_line_conditioner_tb_top;

    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1;
    logic sda_raw = 1'b1;
    logic scl_level, sda_level, scl_rise, scl_fall, start_det, stop_det;

    int checks = 0;
    int bad = 0;
    int n_rise, n_fall, n_start, n_stop, n_sda_tog, n_overlap, n_wide;
    logic last_sda, last_rise, last_fall, last_start, last_stop;

    always #4 clk = ~clk;

    bus_line_conditioner #(.FILT_CYCLES(FILT)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .scl_level(scl_level), .sda_level(sda_level), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    // Monitor: counts events at falling edges, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_rise  += int'(scl_rise);
            n_fall  += int'(scl_fall);
            n_start += int'(start_det);
            n_stop  += int'(stop_det);
            if (sda_level != last_sda) n_sda_tog++;
            if ((start_det && stop_det) || (scl_rise && scl_fall)) n_overlap++;
            if ((scl_rise && last_rise) || (scl_fall && last_fall) ||
                (start_det && last_start) || (stop_det && last_stop)) n_wide++;
        end
        last_sda = sda_level; last_rise = scl_rise; last_fall = scl_fall;
        last_start = start_det; last_stop = stop_det;
    end

    task automatic clr();
        n_rise = 0; n_fall = 0; n_start = 0; n_stop = 0; n_sda_tog = 0;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    localparam int SETTLE = 2 * FILT + 8;

    initial begin
        n_overlap = 0; n_wide = 0; clr();
        last_sda = 1'b1; last_rise = 0; last_fall = 0; last_start = 0; last_stop = 0;
        hold(3);
        // R1: reset state
        chk("R1 scl_level", int'(scl_level), 1);
        chk("R1 sda_level", int'(sda_level), 1);
        chk("R1 pulses", int'(scl_rise | scl_fall | start_det | stop_det), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle levels", int'(scl_level & sda_level), 1);
        chk("R1 first cycle pulses", int'(scl_rise | scl_fall | start_det | stop_det), 0);

        // R4 latency and R6 fall pulse: SCL goes low
        clr();
        scl_raw = 1'b0;
        hold(FILT + 1);
        chk("R4 level before latency", int'(scl_level), 1);
        @(negedge clk);
        chk("R4 level at latency", int'(scl_level), 0);
        chk("R6 fall pulse present", int'(scl_fall), 1);
        hold(SETTLE);
        chk("R6 fall count", n_fall, 1);
        chk("R9 no condition", n_start + n_stop, 0);

        // R2 and R9: SDA excursions of every width while SCL is low
        for (int w = 1; w <= FILT + 2; w++) begin
            clr();
            sda_raw = 1'b0; hold(w); sda_raw = 1'b1; hold(SETTLE);
            chk($sformatf("R2 sda toggles w=%0d", w), n_sda_tog, (w >= FILT) ? 2 : 0);
            chk($sformatf("R9 no cond w=%0d", w), n_start + n_stop, 0);
            chk($sformatf("R2 sda idle w=%0d", w), int'(sda_level), 1);
        end

        // R3, R5 and R6: SCL high excursions of every width
        for (int w = 1; w <= FILT + 2; w++) begin
            clr();
            scl_raw = 1'b1; hold(w); scl_raw = 1'b0; hold(SETTLE);
            chk($sformatf("R5 rise count w=%0d", w), n_rise, (w >= FILT) ? 1 : 0);
            chk($sformatf("R3 fall count w=%0d", w), n_fall, (w >= FILT) ? 1 : 0);
            chk($sformatf("R3 cond w=%0d", w), n_start + n_stop, 0);
        end

        // R7: START with SCL high
        clr();
        scl_raw = 1'b1; hold(SETTLE);
        sda_raw = 1'b0; hold(SETTLE);
        chk("R7 start count", n_start, 1);
        chk("R7 no stop", n_stop, 0);

        // R9: data change while SCL is low, then a repeated START
        clr();
        scl_raw = 1'b0; hold(SETTLE);
        sda_raw = 1'b1; hold(SETTLE);
        scl_raw = 1'b1; hold(SETTLE);
        chk("R9 no cond on data change", n_start + n_stop, 0);
        sda_raw = 1'b0; hold(SETTLE);
        chk("R7 repeated start", n_start, 1);

        // R8: STOP
        clr();
        scl_raw = 1'b0; hold(SETTLE);
        scl_raw = 1'b1; hold(SETTLE);
        sda_raw = 1'b1; hold(SETTLE);
        chk("R8 stop count", n_stop, 1);
        chk("R8 no start", n_start, 0);

        // R2: SDA glitches while SCL is high are not conditions
        for (int w = 1; w < FILT; w++) begin
            clr();
            sda_raw = 1'b0; hold(w); sda_raw = 1'b1; hold(SETTLE);
            chk($sformatf("R2 glitch no cond w=%0d", w), n_start + n_stop, 0);
        end

        // R10: pulse shape over the whole run
        chk("R10 overlap", n_overlap, 0);
        chk("R10 wide pulses", n_wide, 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule